// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a pulse-width modulator and the output pins. When an enabled fault is present, it forces the PWM outputs to a programmed OFF level. The gating path from a fault pin to the outputs has no register in it, so the outputs go to their safe level even if the clock has stopped. There are three fault sources: two external pins that are active low, and an overcurrent comparator signal that is active high. Software can also force the outputs off with a control bit.

Each source has its own enable bit and its own sticky status flag. Any set flag raises the fault interrupt, and software reads the flags to find which source tripped. Recovery is chosen per source. In automatic mode the outputs reconnect at the next PWM cycle boundary, which gives pulse-by-pulse current limiting. In software mode the outputs stay off until software clears the flags, which gives a hard shutdown. The modulator and its counter keep running while the outputs are held off, so the PWM phase is kept when the outputs resume. The fault pins are synchronized to the clock before they touch any state. Only the forcing path uses the raw pins.

Register map, one byte per address (3-bit address): address 0 is the control register, and bit 0 is the software force-off. Address 1 holds the source enables in bits [2:0] and the automatic-restart selects in bits [6:4]. Address 2 holds the status flags in bits [2:0], which are cleared by writing 1. Address 3 holds the per-output OFF level. Address 4 holds the per-output gating mask. In every field, source bit 0 is fault pin 0, bit 1 is fault pin 1 and bit 2 is the comparator. Reads are combinational. Unused addresses and unused bits read 0.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, every register reads 0, `fault_irq` is 0 and `pwm_out` equals `pwm_in`.
- R2: While an enabled source is active on its raw pin, every output whose mask bit is 1 equals its OFF-level bit, with no clock edge needed. Outputs with mask bit 0 always follow `pwm_in`.
- R3: A source whose enable bit is 0 changes neither the outputs nor its status flag.
- R4: While the software force-off bit (address 0, bit 0) is 1, the masked outputs show their OFF levels.
- R5: An enabled source that stays active sets its status flag on the third rising edge after the pin changes, and not before. `fault_irq` is 1 whenever any flag is set.
- R6: Writing 1 to a status bit clears that flag. The clear is ignored while that source's synchronized input is still active.
- R7: For a source in automatic mode, the masked outputs stay off after the pin goes inactive. They reconnect right after the first rising edge at which `pwm_cnt` is 0 and no enabled synchronized source is active. The status flag stays set.
- R8: For a source in software mode, the outputs stay off through counter wraps until the inputs are inactive and every status flag is 0. They reconnect on the rising edge after the clearing write.
- R9: The registers at addresses 0, 1, 3 and 4 read back the value that was written to their defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | N_OUT | Modulator output vector |
| pwm_cnt | input | CNT_W | Modulator master counter |
| fault0_n | input | 1 | External fault pin 0, active low |
| fault1_n | input | 1 | External fault pin 1, active low |
| ocomp | input | 1 | Overcurrent comparator, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pwm_out | output | N_OUT | Gated outputs to the pins |
| fault_irq | output | 1 | Fault interrupt, high while any flag is set |

## Verification
A shutdown latch that is stuck or that releases early shows at the pins. The outputs come back either on a cycle when the counter is not 0 or before the flags are cleared. The bench checks the exact edge on which the outputs come back, and one cycle before it. A corrupted status flag shows up on the next register read and on `fault_irq` in the same cycle. An error in the gating logic appears at once, because the bench checks the outputs between clock edges while pulsing a raw fault.

// File: rtl/pwm_fault_pkg.sv
`timescale 1ns/1ps
// Shared constants for the PWM fault shutdown controller: source count,
// register width, source bit positions and the register address map.
package pwm_fault_pkg;
    localparam int NSRC  = 3;
    localparam int REG_W = 8;
    localparam int ADR_W = 3;

    localparam int SRC_F0 = 0;
    localparam int SRC_F1 = 1;
    localparam int SRC_OC = 2;

    typedef enum logic [ADR_W-1:0] {
        ADR_CTRL = 3'd0,
        ADR_ENA  = 3'd1,
        ADR_STAT = 3'd2,
        ADR_OFF  = 3'd3,
        ADR_MASK = 3'd4
    } reg_adr_e;
endpackage

// File: rtl/pwm_fault_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one chain per bit.
// Assumes the inputs are already converted to active-high and that
// 0 is the safe value to hold in reset.
module pwm_fault_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Move each bit through two flops into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                q[i]      <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/pwm_fault_regs.sv
`timescale 1ns/1ps
// Configuration registers and read mux. Holds force-off, source enables,
// restart selects, OFF levels and the gating mask. The status flags live
// in the latch module; this block only decodes their write-1-to-clear
// strobes and returns them on reads.
// Assumes N_OUT <= REG_W.
module pwm_fault_regs
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ADR_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [NSRC-1:0]  stat,
    output logic             sw_off,
    output logic [NSRC-1:0]  src_en,
    output logic [NSRC-1:0]  auto_rs,
    output logic [N_OUT-1:0] off_lvl,
    output logic [N_OUT-1:0] mask,
    output logic [NSRC-1:0]  clr_req,
    output logic [REG_W-1:0] rdata
);
    // Register writes, decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_off  <= 1'b0;
            src_en  <= '0;
            auto_rs <= '0;
            off_lvl <= '0;
            mask    <= '0;
        end else if (we) begin
            case (addr)
                ADR_CTRL: sw_off <= wdata[0];
                ADR_ENA: begin
                    src_en  <= wdata[NSRC-1:0];
                    auto_rs <= wdata[4 +: NSRC];
                end
                ADR_OFF:  off_lvl <= wdata[N_OUT-1:0];
                ADR_MASK: mask    <= wdata[N_OUT-1:0];
                default: ;
            endcase
        end
    end

    // Write-1-to-clear strobes for the status flags.
    assign clr_req = (we && addr == ADR_STAT) ? wdata[NSRC-1:0] : '0;

    // Combinational read mux; unused bits read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata[0] = sw_off;
            ADR_ENA: begin
                rdata[NSRC-1:0]  = src_en;
                rdata[4 +: NSRC] = auto_rs;
            end
            ADR_STAT: rdata[NSRC-1:0]  = stat;
            ADR_OFF:  rdata[N_OUT-1:0] = off_lvl;
            ADR_MASK: rdata[N_OUT-1:0] = mask;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_fault_latch.sv
`timescale 1ns/1ps
// Sticky status flags and per-source shutdown holds.
// A flag and a hold are set by an enabled, synchronized, active source.
// A flag is cleared by write-1, except while its source is still active.
// A hold is released at a counter-zero edge (automatic mode) or once
// every flag is clear (software mode), and only when no enabled source
// is active.
module pwm_fault_latch
    import pwm_fault_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sync_act,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] auto_rs,
    input  logic            cnt_zero,
    input  logic [NSRC-1:0] clr_req,
    output logic [NSRC-1:0] stat,
    output logic [NSRC-1:0] hold
);
    logic any_act;
    assign any_act = |(sync_act & src_en);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic release_ok;
        // Restart condition picked by this source's mode bit.
        assign release_ok = !any_act && (auto_rs[i] ? cnt_zero : (stat == '0));

        // Sticky flag: set wins, and a clear needs the source to be inactive.
        always_ff @(posedge clk) begin
            if (!rst_n)                          stat[i] <= 1'b0;
            else if (sync_act[i] && src_en[i])   stat[i] <= 1'b1;
            else if (clr_req[i] && !sync_act[i]) stat[i] <= 1'b0;
        end

        // Shutdown hold: keeps the outputs off until the restart rule allows.
        always_ff @(posedge clk) begin
            if (!rst_n)                         hold[i] <= 1'b0;
            else if (sync_act[i] && src_en[i])  hold[i] <= 1'b1;
            else if (hold[i] && release_ok)     hold[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_fault_gate.sv
`timescale 1ns/1ps
// Output gating, all combinational so that it works without a clock.
// A raw enabled fault, a held shutdown or the software force-off sends
// each masked output to its OFF level. Unmasked outputs pass through.
module pwm_fault_gate
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic [N_OUT-1:0] pwm_in,
    input  logic [NSRC-1:0]  raw_act,
    input  logic [NSRC-1:0]  hold,
    input  logic [NSRC-1:0]  src_en,
    input  logic             sw_off,
    input  logic [N_OUT-1:0] off_lvl,
    input  logic [N_OUT-1:0] mask,
    output logic [N_OUT-1:0] pwm_out
);
    logic forced;
    assign forced = sw_off | (|(raw_act & src_en)) | (|(hold & src_en));

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        // Select the OFF level for a masked output while forced.
        assign pwm_out[j] = (forced && mask[j]) ? off_lvl[j] : pwm_in[j];
    end
endmodule

// File: rtl/pwm_fault_guard.sv
`timescale 1ns/1ps
// PWM fault shutdown controller, top level.
// Converts the fault pins to active-high, synchronizes them for the state
// logic, and feeds the raw values straight into the combinational gate.
// Assumes pwm_cnt counts in the modulator's clock domain and is 0 at the
// start of each PWM cycle.
module pwm_fault_guard
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] pwm_in,
    input  logic [CNT_W-1:0] pwm_cnt,
    input  logic             fault0_n,
    input  logic             fault1_n,
    input  logic             ocomp,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [N_OUT-1:0] pwm_out,
    output logic             fault_irq
);
    logic [NSRC-1:0]  raw_act, sync_act, stat, hold, src_en, auto_rs, clr_req;
    logic             sw_off, cnt_zero;
    logic [N_OUT-1:0] off_lvl, mask;

    assign raw_act  = {ocomp, ~fault1_n, ~fault0_n};
    assign cnt_zero = (pwm_cnt == '0);

    pwm_fault_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_act), .q(sync_act)
    );

    pwm_fault_regs #(.N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .stat(stat), .sw_off(sw_off), .src_en(src_en),
        .auto_rs(auto_rs), .off_lvl(off_lvl), .mask(mask),
        .clr_req(clr_req), .rdata(reg_rdata)
    );

    pwm_fault_latch u_latch (
        .clk(clk), .rst_n(rst_n), .sync_act(sync_act), .src_en(src_en),
        .auto_rs(auto_rs), .cnt_zero(cnt_zero), .clr_req(clr_req),
        .stat(stat), .hold(hold)
    );

    pwm_fault_gate #(.N_OUT(N_OUT)) u_gate (
        .pwm_in(pwm_in), .raw_act(raw_act), .hold(hold), .src_en(src_en),
        .sw_off(sw_off), .off_lvl(off_lvl), .mask(mask), .pwm_out(pwm_out)
    );

    assign fault_irq = |stat;
endmodule

// File: rtl/pwm_fault_guard_chk.sv
`timescale 1ns/1ps
// Checker for pwm_fault_guard, attached through bind. It checks the
// gating against the configuration, and checks the flag and hold
// transitions against the restart rules.
module pwm_fault_guard_chk
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] pwm_in,
    input logic [N_OUT-1:0] pwm_out,
    input logic [CNT_W-1:0] pwm_cnt,
    input logic [NSRC-1:0]  raw_act,
    input logic [NSRC-1:0]  sync_act,
    input logic [NSRC-1:0]  src_en,
    input logic [NSRC-1:0]  auto_rs,
    input logic [NSRC-1:0]  stat,
    input logic [NSRC-1:0]  hold,
    input logic             sw_off,
    input logic [N_OUT-1:0] off_lvl,
    input logic [N_OUT-1:0] mask,
    input logic             fault_irq
);
    // R2: an enabled raw fault puts OFF levels on the masked outputs.
    p_raw_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_act & src_en)) |-> ((pwm_out & mask) == (off_lvl & mask)));

    // R2: unmasked outputs always follow the modulator.
    p_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~mask) == (pwm_in & ~mask)));

    // R4: software force-off gates the masked outputs.
    p_swoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |-> ((pwm_out & mask) == (off_lvl & mask)));

    // R3: a flag rises only for a source that was enabled.
    p_flag_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~$past(src_en)) == '0));

    // R5: the interrupt is high whenever a flag is set.
    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != '0) |-> fault_irq);

    // R6: a flag whose source is still active does not clear.
    p_clear_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sync_act) & $past(stat) & ~stat) == '0));

    // R7: an automatic-mode hold releases only on a counter-zero edge.
    p_auto_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(hold) & ~hold & $past(auto_rs))) |-> ($past(pwm_cnt) == '0));

    // R8: a software-mode hold releases only once every flag is clear.
    p_soft_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(hold) & ~hold & ~$past(auto_rs))) |-> ($past(stat) == '0));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_out(pwm_out),
    .pwm_cnt(pwm_cnt), .raw_act(raw_act), .sync_act(sync_act),
    .src_en(src_en), .auto_rs(auto_rs), .stat(stat), .hold(hold),
    .sw_off(sw_off), .off_lvl(off_lvl), .mask(mask), .fault_irq(fault_irq)
);

// File: tb/pwm_fault_guard_bench.sv
`timescale 1ns/1ps
// Bench for pwm_fault_guard: directed fault and restart sequences, then
// random gating patterns using sub-cycle fault pulses.
module pwm_fault_guard_bench;
    localparam int N = 6;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pwm_in = '0;
    logic [CW-1:0] pwm_cnt = '0;
    logic          fault0_n = 1'b1, fault1_n = 1'b1, ocomp = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  pwm_out;
    logic          fault_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    pwm_fault_guard #(.N_OUT(N), .CNT_W(CW)) u_pwm_fault_guard (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_cnt(pwm_cnt),
        .fault0_n(fault0_n), .fault1_n(fault1_n), .ocomp(ocomp),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pwm_out(pwm_out), .fault_irq(fault_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [N-1:0] exp_out(logic [N-1:0] din, logic [N-1:0] off,
                                             logic [N-1:0] msk, logic frc);
        return frc ? ((din & ~msk) | (off & msk)) : din;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then a counter step of period 16 at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        pwm_cnt = (pwm_cnt == 8'd15) ? 8'd0 : pwm_cnt + 8'd1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        pwm_in = 6'b101101;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out", pwm_out, pwm_in);
        check("R1 irq", fault_irq, 0);
        rst_n = 1'b1;
        tick();
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d);
            check("R1 reg", d, 0);
        end

        // R9: readback
        wr(3'd3, 8'h2a); wr(3'd4, 8'h3f); wr(3'd1, 8'h21);
        rd(3'd3, d); check("R9 off", d, 8'h2a);
        rd(3'd4, d); check("R9 mask", d, 8'h3f);
        rd(3'd1, d); check("R9 ena", d, 8'h21);

        // R7: fault pin 0 in automatic mode (enable bit 0, auto bit 4)
        wr(3'd1, 8'h11);
        wr(3'd4, 8'h0f);
        fault0_n = 1'b0;
        #1 check("R2 immediate", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
        tick(); tick();
        rd(3'd2, d); check("R5 not yet", d, 0);
        tick();
        rd(3'd2, d); check("R5 flag set", d, 8'h01);
        check("R5 irq", fault_irq, 1);
        while (pwm_cnt != 8'd5) tick();
        fault0_n = 1'b1;
        tick(); tick(); tick();
        while (pwm_cnt != 8'd0) begin
            check("R7 held", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
            tick();
        end
        check("R7 before zero", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
        tick();
        check("R7 released", pwm_out, pwm_in);
        check("R7 flag kept", fault_irq, 1);
        wr(3'd2, 8'h01);
        rd(3'd2, d); check("R6 clear", d, 0);

        // R3: comparator with its enable bit at 0
        ocomp = 1'b1;
        #1 check("R3 out", pwm_out, pwm_in);
        repeat (4) tick();
        rd(3'd2, d); check("R3 flag", d, 0);
        ocomp = 1'b0;

        // R8 and R6: fault pin 1 in software mode (enable bit 1)
        wr(3'd1, 8'h02);
        fault1_n = 1'b0;
        repeat (3) tick();
        wr(3'd2, 8'h02);
        rd(3'd2, d); check("R6 ignored", d, 8'h02);
        fault1_n = 1'b1;
        repeat (3) tick();
        while (pwm_cnt != 8'd0) tick();
        tick(); tick();
        check("R8 held through wrap", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
        wr(3'd2, 8'h02);
        check("R8 still off", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
        tick();
        check("R8 released", pwm_out, pwm_in);
        check("R8 irq low", fault_irq, 0);

        // R4: software force-off
        wr(3'd0, 8'h01);
        check("R4 forced", pwm_out, exp_out(pwm_in, 6'h2a, 6'h0f, 1));
        wr(3'd0, 8'h00);
        check("R4 off", pwm_out, pwm_in);

        // Random gating patterns, with fault pulses shorter than a clock period
        for (int it = 0; it < 200; it++) begin
            logic [N-1:0] off, msk;
            logic [2:0] en, rawv;
            logic sw;
            off = N'($urandom); msk = N'($urandom);
            en = 3'($urandom); sw = 1'($urandom); rawv = 3'($urandom);
            wr(3'd3, {2'b0, off}); wr(3'd4, {2'b0, msk});
            wr(3'd1, {5'b0, en}); wr(3'd0, {7'b0, sw});
            pwm_in = N'($urandom);
            #1 check("R4 random", pwm_out, exp_out(pwm_in, off, msk, sw));
            #1 {ocomp, fault1_n, fault0_n} = rawv ^ 3'b011;
            #1 check("R2 R3 random", pwm_out, exp_out(pwm_in, off, msk, sw | (|(rawv & en))));
            #1 {ocomp, fault1_n, fault0_n} = 3'b011;
        end
        rd(3'd2, d); check("R3 no flags from pulses", d, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule